// File: doc/BRIEF.md
# Sized register-window access decoder

This block sits between a host request port and a device register window that is split into four sub-windows. These are a capability array, a device status block, a mailbox and a memory-device status block. Each request carries an address, a size code, write data and byte enables. The block checks the request against the width and alignment rules of the sub-window it falls in. A legal request is routed to that sub-window. An illegal one is refused with an error flag and has no side effects.

Read data always comes back right-justified in little-endian order. Byte `addr` sits in bits 7:0, and all bytes beyond the access size are zero. The capability array and the device status block take their contents from wide input vectors, and both are read-only. The mailbox is a small byte-writable store. The memory-device window stores nothing and builds its status value on the fly. Every sub-window base, length and legal-width set is a parameter. Addresses outside all four sub-windows read as zero and take no writes.

Top module: `mmio_window_decoder`

## Requirements
- R1: `req_ready_o` is 0 while `rst_ni` is low and 1 from the first clock after release. Each request accepted on a clock edge (valid and ready both high) produces exactly one `rsp_valid_o` pulse in the following cycle. Back-to-back requests are accepted on consecutive cycles.
- R2: Size code 0, 1, 2 and 3 selects 1, 2, 4 and 8 bytes. A legal read returns byte `addr+i` in bits `8*i+7:8*i` for each i below the size, and zero above it.
- R3: An access whose address is not a multiple of its size sets `rsp_err_o` and returns all-zero data. A misaligned write changes no stored byte.
- R4: Each sub-window has a 4-bit legal-size mask, indexed by size code. A size whose bit is clear sets `rsp_err_o` and returns zero data, and a write of that size has no effect.
- R5: A read of the capability array returns bytes of `cap_data_i`, with window byte k taken from bits `8*k+7:8*k`. This holds for every legal size, including narrow reads inside one 8-byte word.
- R6: A read of the device status window returns bytes of `dev_data_i` in the same byte layout as R5.
- R7: Writes to the capability array, device status or memory-device window complete without error and change nothing. A later read returns the same data.
- R8: Every 8-byte word of the memory-device window reads as 0x14, which is media-status code 01 in bits 3:2 and mailbox-ready in bit 4. All other bits are zero.
- R9: A legal mailbox write stores byte `addr+i` from `req_wdata_i[8*i+7:8*i]` for each i below the size where `req_be_i[i]` is set. Other bytes keep their value. A write response has zero data and no error.
- R10: An address outside all four sub-windows reads as zero without error, and a write there stores nothing.
- R11: Reset clears every mailbox byte to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Byte address inside the window |
| req_size_i | input | 2 | Size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_wdata_i | input | 64 | Right-justified write data |
| req_be_i | input | 8 | Byte enables, bit i for byte addr+i |
| cap_data_i | input | CAP_LEN*8 | Capability array contents |
| dev_data_i | input | DEV_LEN*8 | Device status contents |
| rsp_valid_o | output | 1 | Response strobe, one cycle after accept |
| rsp_err_o | output | 1 | Illegal access flag |
| rsp_rdata_o | output | 64 | Right-justified read data |

## Verification
The bench keeps the default bases and lengths. These put the capability array at 0 (128 bytes), device status at 0x80 (32 bytes), the mailbox at 0x100 (64 bytes) and the memory-device window at 0x200 (8 bytes), with a gap above 0x208 that is reachable for the out-of-window cases. It overrides the device-status mask to 4'b0111 and the memory-device mask to 4'b1100. With these masks a legal misaligned-free request can still be refused for its width alone, which brings the per-window rule of R4 within reach alongside the alignment rule of R3.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;

  typedef enum logic [2:0] {
    WIN_NONE = 3'd0,
    WIN_CAP  = 3'd1,
    WIN_DEV  = 3'd2,
    WIN_MBX  = 3'd3,
    WIN_MDEV = 3'd4
  } win_e;

  typedef enum logic [1:0] {
    SZ_1B = 2'd0,
    SZ_2B = 2'd1,
    SZ_4B = 2'd2,
    SZ_8B = 2'd3
  } size_e;

  // media status = 01 at [3:2], mailbox ready at [4]
  localparam logic [63:0] MDEV_STATUS_WORD = 64'h14;

  function automatic logic [7:0] size_lanes(input size_e sz);
    case (sz)
      SZ_1B:   return 8'h01;
      SZ_2B:   return 8'h03;
      SZ_4B:   return 8'h0F;
      default: return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/mmio_win_decode.sv
module mmio_win_decode
  import mmio_dec_pkg::*;
#(
  parameter int unsigned AW        = 12,
  parameter int unsigned CAP_BASE  = 0,
  parameter int unsigned CAP_LEN   = 128,
  parameter int unsigned DEV_BASE  = 128,
  parameter int unsigned DEV_LEN   = 32,
  parameter int unsigned MBX_BASE  = 256,
  parameter int unsigned MBX_LEN   = 64,
  parameter int unsigned MDEV_BASE = 512,
  parameter int unsigned MDEV_LEN  = 8,
  parameter logic [3:0]  CAP_MASK  = 4'b1111,
  parameter logic [3:0]  DEV_MASK  = 4'b1111,
  parameter logic [3:0]  MBX_MASK  = 4'b1111,
  parameter logic [3:0]  MDEV_MASK = 4'b1111
) (
  input  logic [AW-1:0] addr_i,
  input  size_e         size_i,
  output win_e          win_o,
  output logic [AW-1:0] off_o,
  output logic          misalign_o,
  output logic          legal_o
);

  localparam int unsigned NWIN = 4;
  localparam int unsigned WBASE [NWIN] = '{CAP_BASE, DEV_BASE, MBX_BASE, MDEV_BASE};
  localparam int unsigned WLEN  [NWIN] = '{CAP_LEN, DEV_LEN, MBX_LEN, MDEV_LEN};
  localparam logic [3:0]  WMASK [NWIN] = '{CAP_MASK, DEV_MASK, MBX_MASK, MDEV_MASK};

  logic [31:0]     addr32;
  logic [NWIN-1:0] hit;
  logic            width_ok;

  assign addr32 = 32'(addr_i);

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign hit[i] = (addr32 >= WBASE[i]) && (addr32 < WBASE[i] + WLEN[i]);
  end

  // lowest-indexed hit wins if windows overlap
  always_comb begin
    win_o    = WIN_NONE;
    off_o    = '0;
    width_ok = 1'b1;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) begin
        win_o    = win_e'(3'(i + 1));
        off_o    = addr_i - AW'(WBASE[i]);
        width_ok = WMASK[i][size_i];
      end
    end
  end

  always_comb begin
    case (size_i)
      SZ_1B:   misalign_o = 1'b0;
      SZ_2B:   misalign_o = addr_i[0];
      SZ_4B:   misalign_o = |addr_i[1:0];
      default: misalign_o = |addr_i[2:0];
    endcase
  end

  assign legal_o = !misalign_o && width_ok;

endmodule

// File: rtl/mmio_lane_align.sv
module mmio_lane_align
  import mmio_dec_pkg::*;
(
  input  logic [63:0] word_i,
  input  logic [2:0]  boff_i,
  input  size_e       size_i,
  output logic [63:0] data_o
);

  logic [63:0] shifted;
  logic [7:0]  lanes;

  assign shifted = word_i >> {boff_i, 3'b000};
  assign lanes   = size_lanes(size_i);

  for (genvar b = 0; b < 8; b++) begin : g_lane
    assign data_o[8*b +: 8] = lanes[b] ? shifted[8*b +: 8] : 8'h00;
  end

endmodule

// File: rtl/mmio_mbox_store.sv
module mmio_mbox_store #(
  parameter int unsigned WORDS = 8,
  localparam int unsigned IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    be_i,
  input  logic [63:0]   wdata_i,
  output logic [63:0]   rdata_o
);

  logic [WORDS-1:0][63:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else if (we_i) begin
      for (int w = 0; w < WORDS; w++) begin
        if (idx_i == IW'(w)) begin
          for (int b = 0; b < 8; b++) begin
            if (be_i[b]) mem_q[w][8*b +: 8] <= wdata_i[8*b +: 8];
          end
        end
      end
    end
  end

  assign rdata_o = mem_q[idx_i];

  p_mem_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));

endmodule

// File: rtl/mmio_window_decoder.sv
module mmio_window_decoder
  import mmio_dec_pkg::*;
#(
  parameter int unsigned AW        = 12,
  parameter int unsigned CAP_BASE  = 0,
  parameter int unsigned CAP_LEN   = 128,
  parameter int unsigned DEV_BASE  = 128,
  parameter int unsigned DEV_LEN   = 32,
  parameter int unsigned MBX_BASE  = 256,
  parameter int unsigned MBX_LEN   = 64,
  parameter int unsigned MDEV_BASE = 512,
  parameter int unsigned MDEV_LEN  = 8,
  parameter logic [3:0]  CAP_MASK  = 4'b1111,
  parameter logic [3:0]  DEV_MASK  = 4'b1111,
  parameter logic [3:0]  MBX_MASK  = 4'b1111,
  parameter logic [3:0]  MDEV_MASK = 4'b1111
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [AW-1:0]        req_addr_i,
  input  logic [1:0]           req_size_i,
  input  logic [63:0]          req_wdata_i,
  input  logic [7:0]           req_be_i,
  input  logic [CAP_LEN*8-1:0] cap_data_i,
  input  logic [DEV_LEN*8-1:0] dev_data_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_err_o,
  output logic [63:0]          rsp_rdata_o
);

  localparam int unsigned CAP_WORDS = CAP_LEN / 8;
  localparam int unsigned DEV_WORDS = DEV_LEN / 8;
  localparam int unsigned MBX_WORDS = MBX_LEN / 8;
  localparam int unsigned MIW       = (MBX_WORDS > 1) ? $clog2(MBX_WORDS) : 1;

  size_e         size;
  win_e          win;
  logic [AW-1:0] off;
  logic          misalign, legal, accept, ready_q;
  logic [63:0]   cap_word, dev_word, mbx_word, sel_word, aligned_rd;
  logic [7:0]    be_sh;
  logic [63:0]   wdata_sh;
  logic          mbx_we;

  assign size   = size_e'(req_size_i);
  assign accept = req_valid_i && ready_q;

  mmio_win_decode #(
    .AW(AW),
    .CAP_BASE(CAP_BASE), .CAP_LEN(CAP_LEN),
    .DEV_BASE(DEV_BASE), .DEV_LEN(DEV_LEN),
    .MBX_BASE(MBX_BASE), .MBX_LEN(MBX_LEN),
    .MDEV_BASE(MDEV_BASE), .MDEV_LEN(MDEV_LEN),
    .CAP_MASK(CAP_MASK), .DEV_MASK(DEV_MASK),
    .MBX_MASK(MBX_MASK), .MDEV_MASK(MDEV_MASK)
  ) u_decode (
    .addr_i     (req_addr_i),
    .size_i     (size),
    .win_o      (win),
    .off_o      (off),
    .misalign_o (misalign),
    .legal_o    (legal)
  );

  // read-only windows are fetched a whole 8-byte word at a time
  always_comb begin
    cap_word = '0;
    for (int w = 0; w < CAP_WORDS; w++)
      if (off[AW-1:3] == (AW-3)'(w)) cap_word = cap_data_i[64*w +: 64];
  end

  always_comb begin
    dev_word = '0;
    for (int w = 0; w < DEV_WORDS; w++)
      if (off[AW-1:3] == (AW-3)'(w)) dev_word = dev_data_i[64*w +: 64];
  end

  assign be_sh    = 8'((req_be_i & size_lanes(size)) << off[2:0]);
  assign wdata_sh = req_wdata_i << {off[2:0], 3'b000};
  assign mbx_we   = accept && legal && req_write_i && (win == WIN_MBX);

  mmio_mbox_store #(.WORDS(MBX_WORDS)) u_mbox (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mbx_we),
    .idx_i   (off[3 +: MIW]),
    .be_i    (be_sh),
    .wdata_i (wdata_sh),
    .rdata_o (mbx_word)
  );

  always_comb begin
    case (win)
      WIN_CAP:  sel_word = cap_word;
      WIN_DEV:  sel_word = dev_word;
      WIN_MBX:  sel_word = mbx_word;
      WIN_MDEV: sel_word = MDEV_STATUS_WORD;
      default:  sel_word = '0;
    endcase
  end

  mmio_lane_align u_align (
    .word_i (sel_word),
    .boff_i (off[2:0]),
    .size_i (size),
    .data_o (aligned_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q     <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_o <= accept;
      rsp_err_o   <= accept && !legal;
      rsp_rdata_o <= (accept && legal && !req_write_i) ? aligned_rd : '0;
    end
  end

  assign req_ready_o = ready_q;

  p_ready_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> req_ready_o);

  p_rsp_after_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rsp_valid_o);

  p_no_rsp_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !rsp_valid_o);

  p_misalign_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && misalign) |=> (rsp_valid_o && rsp_err_o));

  p_err_zero_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> (rsp_rdata_o == 64'h0));

  p_mdev_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && legal && !req_write_i && win == WIN_MDEV && size == SZ_8B)
      |=> (rsp_rdata_o == 64'h14));

endmodule

// File: tb/tb_mmio_window_decoder.sv
module tb_mmio_window_decoder;

  localparam int AW = 12;
  localparam int CAP_LEN = 128;
  localparam int DEV_LEN = 32;
  localparam logic [3:0] DEV_M  = 4'b0111;
  localparam logic [3:0] MDEV_M = 4'b1100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0] req_be = '0;
  logic [CAP_LEN*8-1:0] cap_data;
  logic [DEV_LEN*8-1:0] dev_data;
  logic req_ready, rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;

  int tests = 0, fails = 0;
  logic [7:0] mbx_m [64];
  logic exp_err_q [$];
  logic [63:0] exp_dat_q [$];
  string tag_q [$];

  always #5 clk = ~clk;

  mmio_window_decoder #(.AW(AW), .DEV_MASK(DEV_M), .MDEV_MASK(MDEV_M)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .req_be_i(req_be), .cap_data_i(cap_data), .dev_data_i(dev_data),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata)
  );

  function automatic int win_of(int a);
    if (a < 128) return 1;
    if (a >= 128 && a < 160) return 2;
    if (a >= 256 && a < 320) return 3;
    if (a >= 512 && a < 520) return 4;
    return 0;
  endfunction

  function automatic logic [7:0] model_byte(int a);
    case (win_of(a))
      1: return 8'(a * 7 + 3);
      2: return 8'(8'hC0 + (a - 128));
      3: return mbx_m[a - 256];
      4: return ((a - 512) % 8 == 0) ? 8'h14 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit model_legal(int a, int s);
    logic [3:0] m;
    if (a % (1 << s) != 0) return 1'b0;
    case (win_of(a))
      2: m = DEV_M;
      4: m = MDEV_M;
      default: m = 4'b1111;
    endcase
    return m[s];
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(bit wr, int a, int s, logic [63:0] wd, logic [7:0] be, string tag);
    logic [63:0] d;
    bit ok;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a);
    req_size = 2'(s); req_wdata = wd; req_be = be;
    ok = model_legal(a, s);
    d = '0;
    if (ok && wr && win_of(a) == 3) begin
      for (int i = 0; i < (1 << s); i++)
        if (be[i]) mbx_m[a + i - 256] = wd[8*i +: 8];
    end else if (ok && !wr) begin
      for (int i = 0; i < (1 << s); i++) d[8*i +: 8] = model_byte(a + i);
    end
    exp_err_q.push_back(!ok);
    exp_dat_q.push_back(d);
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (tag_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R1 unexpected response actual=1 expected=0");
      end else begin
        string t;
        logic e;
        logic [63:0] dd;
        t = tag_q.pop_front(); e = exp_err_q.pop_front(); dd = exp_dat_q.pop_front();
        check({t, " err"}, 64'(rsp_err), 64'(e));
        check({t, " data"}, rsp_rdata, dd);
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < CAP_LEN; k++) cap_data[8*k +: 8] = 8'(k * 7 + 3);
    for (int k = 0; k < DEV_LEN; k++) dev_data[8*k +: 8] = 8'(8'hC0 + k);
    for (int k = 0; k < 64; k++) mbx_m[k] = 8'h00;

    repeat (3) @(negedge clk);
    check("R1 ready in reset", 64'(req_ready), 64'd0);
    check("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", 64'(req_ready), 64'd1);

    req(0, 256, 3, '0, '0, "R11 mailbox zero after reset");
    req(0, 0, 3, '0, '0, "R5 R2 cap 8B");
    req(0, 4, 2, '0, '0, "R5 R2 cap 4B");
    req(0, 6, 1, '0, '0, "R5 R2 cap 2B");
    req(0, 13, 0, '0, '0, "R5 R2 cap 1B");
    req(0, 120, 3, '0, '0, "R5 cap last word");
    req(0, 132, 2, '0, '0, "R6 dev 4B");
    req(0, 129, 0, '0, '0, "R6 dev 1B");
    req(0, 128, 3, '0, '0, "R4 dev 8B refused");
    req(0, 2, 2, '0, '0, "R3 misaligned 4B read");
    req(1, 257, 1, 64'hBEEF, 8'hFF, "R3 misaligned mailbox write");
    req(0, 256, 3, '0, '0, "R3 no write after misalign");
    req(1, 256, 3, 64'h0123_4567_89AB_CDEF, 8'hFF, "R9 mailbox 8B write");
    req(1, 264, 2, 64'hDDCC_BBAA, 8'b0101, "R9 mailbox 4B masked write");
    req(1, 271, 0, 64'h5A, 8'h01, "R9 mailbox 1B write");
    req(0, 256, 3, '0, '0, "R9 readback word0");
    req(0, 264, 3, '0, '0, "R9 readback word1");
    req(0, 266, 1, '0, '0, "R9 R2 readback 2B");
    req(1, 0, 3, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R7 cap write ignored");
    req(1, 128, 2, 64'hFFFF_FFFF, 8'hFF, "R7 dev write ignored");
    req(1, 512, 3, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R7 mdev write ignored");
    req(0, 0, 3, '0, '0, "R7 cap unchanged");
    req(0, 128, 2, '0, '0, "R7 dev unchanged");
    req(0, 512, 3, '0, '0, "R8 R7 mdev 8B");
    req(0, 512, 2, '0, '0, "R8 mdev 4B low");
    req(0, 516, 2, '0, '0, "R8 mdev 4B high");
    req(0, 512, 0, '0, '0, "R4 mdev 1B refused");
    req(1, 272, 1, 64'h1122, 8'h03, "R4 mailbox 2B write");
    req(1, 1024, 3, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R10 outside write");
    req(0, 1024, 3, '0, '0, "R10 outside read");
    req(0, 200, 2, '0, '0, "R10 gap read");
    req(0, 272, 3, '0, '0, "R9 readback word2");
    idle();
    repeat (3) @(negedge clk);
    check("R1 all responses seen", 64'(tag_q.size()), 64'd0);
    finish_run();
  end

endmodule